// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Less-Than

This block is a purely combinational arithmetic logic unit for a W-bit integer datapath (W = 32 by default). It takes two operands and a 3-bit operation code, and returns a W-bit result together with a zero flag, the carry leaving the top bit and a signed-overflow flag. The datapath is a chain of identical one-bit cells. Each cell holds an AND gate, an OR gate and a full adder, and a four-way picker chooses which of these drives the cell's result bit. Carries ripple from bit 0 upward.

Subtraction reuses the adder. One control line inverts operand b in every cell and also serves as the carry into bit 0, so a − b is computed as a + ~b + 1. For the signed less-than operation, the sum bit of the top cell (the sign of a − b) is routed back to the less-than input of bit 0. Every other cell sees a constant 0 on that input, so the result is 1 or 0. A datapath tests two values for equality by subtracting them and reading the zero flag.

Top module: `bsl_alu`

## Requirements
- R1: Code 3'b000 returns the bitwise AND of a and b.
- R2: Code 3'b001 returns the bitwise OR of a and b.
- R3: Code 3'b010 returns (a + b) mod 2^W, and `cout` equals bit W of the unsigned (W+1)-bit sum.
- R4: Code 3'b110 returns (a − b) mod 2^W, and `cout` is the carry out of a + ~b + 1. This carry is 1 exactly when a ≥ b taken as unsigned numbers.
- R5: Code 3'b111 returns a value whose bit 0 is the top bit of (a − b) mod 2^W and whose bits W−1..1 are all 0. This holds even when the subtraction overflows.
- R6: `zero` is 1 exactly when every bit of `res` is 0, for every code.
- R7: For code 3'b010, `ovf` is 1 exactly when a and b have the same sign bit and the sign bit of the sum differs from it.
- R8: For codes 3'b110 and 3'b111, `ovf` is 1 exactly when a and b have different sign bits and the sign bit of the difference differs from the sign bit of a.
- R9: `ovf` is never 1 when operands of opposite sign are added, or when operands of equal sign are subtracted.
- R10: `ovf` is 0 for codes 3'b000 and 3'b001.
- R11: Codes 3'b011, 3'b100 and 3'b101 return all zeros in `res`, so `zero` is 1 and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand |
| opb | input | W | Second operand, inverted internally for subtract and less-than |
| ctl | input | 3 | Operation code; bit 2 is the b-negate line |
| res | output | W | Selected result |
| zero | output | 1 | High when res is all zeros |
| cout | output | 1 | Carry leaving the top cell |
| ovf | output | 1 | Signed overflow for add, subtract and less-than |

## Verification
The bench builds the block with its default width of 32 bits. At that width the directed cases reach the exact boundaries: the largest positive value plus one, the most negative value minus one, and a less-than whose difference wraps. These cases check the overflow rules and show that the less-than bit follows the raw sign of the difference. Random operands run across all eight codes, including the three unused ones, so carry propagation through the full chain is exercised alongside the flag logic.

// File: rtl/bsl_alu_pkg.sv
package bsl_alu_pkg;
  localparam int CTL_W = 3;

  localparam logic [CTL_W-1:0] OP_AND = 3'b000;
  localparam logic [CTL_W-1:0] OP_OR  = 3'b001;
  localparam logic [CTL_W-1:0] OP_ADD = 3'b010;
  localparam logic [CTL_W-1:0] OP_SUB = 3'b110;
  localparam logic [CTL_W-1:0] OP_SLT = 3'b111;

  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } pick_t;
endpackage

// File: rtl/bsl_alu_decode.sv
module bsl_alu_decode
  import bsl_alu_pkg::*;
(
  input  logic [CTL_W-1:0] ctl,
  output pick_t            pick,
  output logic             bneg,
  output logic             valid,
  output logic             arith
);
  always_comb begin
    pick  = PICK_AND;
    valid = 1'b1;
    arith = 1'b0;
    unique case (ctl)
      OP_AND: pick = PICK_AND;
      OP_OR:  pick = PICK_OR;
      OP_ADD: begin pick = PICK_SUM;  arith = 1'b1; end
      OP_SUB: begin pick = PICK_SUM;  arith = 1'b1; end
      OP_SLT: begin pick = PICK_LESS; arith = 1'b1; end
      default: valid = 1'b0;
    endcase
  end

  // the top code bit doubles as the b-negate line and the initial carry
  assign bneg = ctl[CTL_W-1];
endmodule

// File: rtl/bsl_alu_slice.sv
module bsl_alu_slice
  import bsl_alu_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  logic  bneg,
  input  logic  cin,
  input  logic  less,
  input  pick_t pick,
  output logic  res,
  output logic  sum,
  output logic  cout
);
  logic bx;

  assign bx   = bneg ? ~b : b;
  assign sum  = a ^ bx ^ cin;
  assign cout = (a & bx) | (a & cin) | (bx & cin);

  always_comb begin
    unique case (pick)
      PICK_AND:  res = a & bx;
      PICK_OR:   res = a | bx;
      PICK_SUM:  res = sum;
      PICK_LESS: res = less;
      default:   res = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsl_alu.sv
module bsl_alu
  import bsl_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [CTL_W-1:0] ctl,
  output logic [W-1:0]     res,
  output logic             zero,
  output logic             cout,
  output logic             ovf
);
  localparam int TOP = W - 1;

  pick_t        pick;
  logic         bneg;
  logic         valid;
  logic         arith;
  logic [W:0]   carry;
  logic [W-1:0] sums;
  logic [W-1:0] raw;
  logic [W-1:0] less_in;
  logic         set_bit;

  bsl_alu_decode u_dec (
    .ctl   (ctl),
    .pick  (pick),
    .bneg  (bneg),
    .valid (valid),
    .arith (arith)
  );

  assign carry[0] = bneg;
  assign set_bit  = sums[TOP];

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_cell
      if (i == 0) begin : g_lsb
        assign less_in[i] = set_bit;
      end else begin : g_rest
        assign less_in[i] = 1'b0;
      end

      bsl_alu_slice u_cell (
        .a    (opa[i]),
        .b    (opb[i]),
        .bneg (bneg),
        .cin  (carry[i]),
        .less (less_in[i]),
        .pick (pick),
        .res  (raw[i]),
        .sum  (sums[i]),
        .cout (carry[i+1])
      );
    end
  endgenerate

  assign res  = valid ? raw : '0;
  assign zero = ~|res;
  assign cout = carry[W];
  assign ovf  = arith & (carry[TOP] ^ carry[W]);
endmodule

// File: rtl/bsl_alu_chk.sv
module bsl_alu_chk
  import bsl_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0]     opa,
  input logic [W-1:0]     opb,
  input logic [CTL_W-1:0] ctl,
  input logic [W-1:0]     res,
  input logic             zero,
  input logic             ovf
);
  always_comb begin
    assert_zero_flag_R6: assert (zero == (res == '0));
    if (ctl == OP_AND || ctl == OP_OR) begin
      assert_logic_no_ovf_R10: assert (!ovf);
    end
    if (ctl == OP_ADD && (opa[W-1] != opb[W-1])) begin
      assert_add_mixed_sign_R9: assert (!ovf);
    end
    if (ctl == OP_SUB && (opa[W-1] == opb[W-1])) begin
      assert_sub_same_sign_R9: assert (!ovf);
    end
    if (ctl == OP_SLT) begin
      assert_slt_upper_clear_R5: assert (res[W-1:1] == '0);
    end
    if (ctl == 3'b011 || ctl == 3'b100 || ctl == 3'b101) begin
      assert_unused_zero_R11: assert (res == '0 && !ovf);
    end
  end
endmodule

bind bsl_alu bsl_alu_chk #(.W(W)) u_chk (
  .opa  (opa),
  .opb  (opb),
  .ctl  (ctl),
  .res  (res),
  .zero (zero),
  .ovf  (ovf)
);

// File: tb/bsl_alu_test.sv
module bsl_alu_test;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa, opb;
  logic [2:0]   ctl;
  logic [W-1:0] res;
  logic         zero, cout, ovf;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit done    = 0;

  bsl_alu #(.W(W)) uut (
    .opa(opa), .opb(opb), .ctl(ctl),
    .res(res), .zero(zero), .cout(cout), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3/R7";
      3'b110: return "R4/R8";
      3'b111: return "R5/R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] c);
    // returns {ovf, cout, res}
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         v, co;
    s = '0; r = '0; v = 1'b0; co = 1'b0;
    case (c)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        s = {1'b0, a} + {1'b0, b}; r = s[W-1:0]; co = s[W];
        v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b110, 3'b111: begin
        s = {1'b0, a} + {1'b0, ~b} + 1; co = s[W];
        v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
        r = (c == 3'b110) ? s[W-1:0] : {{(W-1){1'b0}}, s[W-1]};
      end
      default: r = '0;
    endcase
    return {v, co, r};
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] c);
    logic [W+1:0] exp;
    bit arith;
    @(negedge clk);
    opa = a; opb = b; ctl = c;
    @(posedge clk);
    #1;
    exp   = model(a, b, c);
    arith = (c == 3'b010 || c == 3'b110 || c == 3'b111);
    vec_cnt++;
    if (res !== exp[W-1:0]) begin
      bad_cnt++;
      $display("FAIL %s res a=%h b=%h ctl=%b actual=%h expected=%h", req_of(c), a, b, c, res, exp[W-1:0]);
    end
    if (zero !== (exp[W-1:0] == '0)) begin
      bad_cnt++;
      $display("FAIL R6 zero a=%h b=%h ctl=%b actual=%b expected=%b", a, b, c, zero, exp[W-1:0] == '0);
    end
    if (ovf !== exp[W+1]) begin
      bad_cnt++;
      $display("FAIL %s ovf (R10 for logic) ctl=%b actual=%b expected=%b", req_of(c), c, ovf, exp[W+1]);
    end
    if (arith && cout !== exp[W]) begin
      bad_cnt++;
      $display("FAIL %s cout ctl=%b actual=%b expected=%b", req_of(c), c, cout, exp[W]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad_cnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; opa = '0; opb = '0; ctl = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-like idle state: AND of zeros gives zero flag (R1, R6)
    apply(32'h0, 32'h0, 3'b000);
    // R1/R2 patterns
    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);
    apply(32'hF0F0_1234, 32'h0FF0_0000, 3'b001);
    // R3/R7 boundaries
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'h8000_0000, 32'h8000_0000, 3'b010);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b010); // R9 mixed signs
    // R4/R8 boundaries
    apply(32'h0000_0000, 32'h0000_0001, 3'b110);
    apply(32'h8000_0000, 32'h0000_0001, 3'b110);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    apply(32'h1234_5678, 32'h1234_5678, 3'b110); // R6 equality
    // R5 including overflowed difference
    apply(32'h0000_0003, 32'h0000_0005, 3'b111);
    apply(32'hFFFF_FFFB, 32'h0000_0002, 3'b111);
    apply(32'h8000_0000, 32'h0000_0001, 3'b111);
    apply(32'h0000_0005, 32'h0000_0005, 3'b111);
    // R11 unused codes
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b100);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b101);

    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = (k % 7 == 0) ? ra : $urandom;
      apply(ra, rb, 3'($urandom % 8));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule